// File: doc/BRIEF.md
# Byte-Lane Register Access Adapter

This adapter sits between a host that issues register accesses of 1, 2, 3 or 4 bytes at any byte offset inside a 128-byte I/O window and three register targets that accept only whole 32-bit words. The targets are a bank of core registers, a DMA channel register bank, and a single control word. The adapter decodes the window, issues word accesses to the selected target, cuts the requested bytes out of read words, and widens narrow or unaligned writes into a fetch followed by a merged full-word write.

The host hands over one access at a time with a valid/ready handshake. The adapter returns a one-cycle completion pulse that carries read data and an error flag. Target accesses use read and write strobes, a one-hot target select, and a word index. Each target returns its read word in the same cycle it is addressed. The core target also presents the copy of the value last written to the addressed register, and widened writes merge into that copy.

Top module: `regwin_adapter`

## Requirements
- R1: Decoding uses the byte address. 0x00–0x3F selects the core (t_sel bit 0) with word index addr[5:2]. 0x40–0x5F selects the DMA bank (t_sel bit 1) with index (addr−0x40)>>2. The word 0x70–0x73 selects the control register (t_sel bit 2, index 0). No more than one select bit is ever high.
- R2: A valid read performs one target read cycle. It returns the target word shifted right by 8×(addr mod 4) and masked to the access size, with byte 0 as the least significant. h_done rises two cycles after acceptance with h_err low.
- R3: A read of an address outside the three targets returns 0 with h_err low. No target strobe is issued, and h_done rises one cycle after acceptance.
- R4: A write to an address outside the three targets is dropped. No target strobe is issued, and h_done rises one cycle after acceptance with h_err low.
- R5: An aligned 4-byte write issues exactly one target write cycle carrying h_wdata unchanged and no read. h_done rises two cycles after acceptance.
- R6: A write narrower than 4 bytes, or at a non-zero byte offset, issues one target read cycle and then one target write cycle at the same target and index. The written word is the fetched word with only the addressed bytes replaced by the low bytes of h_wdata. h_done rises three cycles after acceptance.
- R7: For a widened write to the core, the merge starts from core_wcopy. core_rdata is not used. The DMA and control targets merge from their read data.
- R8: h_ready is low in every cycle in which a target strobe is active. A request is taken only in a cycle where h_valid and h_ready are both high.
- R9: h_size gives the byte count 1 to 4. A size of 0 or above 4 completes with h_err high and h_rdata 0, one cycle after acceptance, with no target strobe.
- R10: An access for which (addr mod 4) + size exceeds 4 would cross a word boundary. It completes with h_err high and h_rdata 0, one cycle after acceptance, with no target strobe.
- R11: After reset h_ready is high, and h_done, t_rd and t_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host request present |
| h_ready | output | 1 | Adapter can take a request |
| h_we | input | 1 | 1 = write, 0 = read |
| h_addr | input | 7 | Byte address in the window |
| h_size | input | 3 | Access size in bytes (1–4) |
| h_wdata | input | 32 | Write data, right-aligned |
| h_done | output | 1 | One-cycle completion pulse |
| h_err | output | 1 | Size or crossing error, valid with h_done |
| h_rdata | output | 32 | Right-aligned read data, valid with h_done |
| t_rd | output | 1 | Target read strobe |
| t_wr | output | 1 | Target write strobe |
| t_sel | output | 3 | One-hot target select: core, DMA, control |
| t_idx | output | 4 | Word index within the selected target |
| t_wdata | output | 32 | Word written to the target |
| core_rdata | input | 32 | Core read word at t_idx |
| core_wcopy | input | 32 | Last value written to the core register at t_idx |
| dma_rdata | input | 32 | DMA bank word at t_idx |
| ctl_rdata | input | 32 | Control word |

## Verification
The bench builds the adapter with its default window parameters: core below 0x40, DMA bank up to 0x60, control word at 0x70. With these values the first and last slot of each bank, the unused gaps at 0x60 and 0x74 and above, and the control word's byte lanes can all be reached from 7-bit addresses. The bench's core model returns read data that differs from its write copy, which makes the merge source visible in later reads. Each access is checked for completion latency, the number of target read and write cycles, and the data and error flag it returns.

// File: rtl/regwin_adapter.sv
module regwin_adapter #(
  parameter int AW       = 7,
  parameter int CORE_END = 'h40,
  parameter int DMA_END  = 'h60,
  parameter int CTL_WORD = 'h70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  output logic          h_ready,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [2:0]    h_size,
  input  logic [31:0]   h_wdata,
  output logic          h_done,
  output logic          h_err,
  output logic [31:0]   h_rdata,
  output logic          t_rd,
  output logic          t_wr,
  output logic [2:0]    t_sel,
  output logic [3:0]    t_idx,
  output logic [31:0]   t_wdata,
  input  logic [31:0]   core_rdata,
  input  logic [31:0]   core_wcopy,
  input  logic [31:0]   dma_rdata,
  input  logic [31:0]   ctl_rdata
);
  localparam logic [AW-1:0] CORE_E = AW'(CORE_END);
  localparam logic [AW-1:0] DMA_E  = AW'(DMA_END);
  localparam logic [AW-1:0] CTL_W  = AW'(CTL_WORD);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_FETCH, S_WRITE} st_t;
  st_t st;

  logic          we_q, narrow_q;
  logic [1:0]    off_q;
  logic [2:0]    size_q;
  logic [31:0]   wdata_q, merge_q;
  logic [2:0]    sel_q;
  logic [3:0]    idx_q;

  wire accept = h_valid && h_ready;
  wire size_bad = (h_size == 3'd0) || (h_size > 3'd4);
  wire crosses = ({2'b00, h_addr[1:0]} + {1'b0, h_size}) > 4'd4;
  wire [AW-1:0] dma_off = h_addr - CORE_E;
  wire [AW-1:0] word_addr = {h_addr[AW-1:2], 2'b00};

  logic [2:0] a_sel;
  logic [3:0] a_idx;
  always_comb begin
    a_sel = 3'b000;
    a_idx = 4'd0;
    if (h_addr < CORE_E) begin
      a_sel = 3'b001;
      a_idx = h_addr[5:2];
    end else if (h_addr < DMA_E) begin
      a_sel = 3'b010;
      a_idx = dma_off[5:2];
    end else if (word_addr == CTL_W) begin
      a_sel = 3'b100;
    end
  end

  wire [31:0] lane = (size_q == 3'd1) ? 32'h0000_00FF :
                     (size_q == 3'd2) ? 32'h0000_FFFF :
                     (size_q == 3'd3) ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
  wire [4:0]  shamt = {off_q, 3'b000};
  wire [31:0] lane_sh = lane << shamt;

  wire [31:0] read_src  = sel_q[0] ? core_rdata : sel_q[1] ? dma_rdata : ctl_rdata;
  wire [31:0] fetch_src = sel_q[0] ? core_wcopy : sel_q[1] ? dma_rdata : ctl_rdata;
  wire [31:0] extracted = (read_src >> shamt) & lane;
  wire [31:0] merged    = (fetch_src & ~lane_sh) | ((wdata_q & lane) << shamt);

  assign h_ready = (st == S_IDLE);
  assign t_rd    = (st == S_READ) || (st == S_FETCH);
  assign t_wr    = (st == S_WRITE);
  assign t_sel   = (st == S_IDLE) ? 3'b000 : sel_q;
  assign t_idx   = idx_q;
  assign t_wdata = narrow_q ? merge_q : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      h_done   <= 1'b0;
      h_err    <= 1'b0;
      h_rdata  <= '0;
      we_q     <= 1'b0;
      narrow_q <= 1'b0;
      off_q    <= '0;
      size_q   <= '0;
      wdata_q  <= '0;
      merge_q  <= '0;
      sel_q    <= '0;
      idx_q    <= '0;
    end else begin
      h_done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          we_q    <= h_we;
          off_q   <= h_addr[1:0];
          size_q  <= h_size;
          wdata_q <= h_wdata;
          sel_q   <= a_sel;
          idx_q   <= a_idx;
          if (size_bad || crosses) begin
            h_done  <= 1'b1;
            h_err   <= 1'b1;
            h_rdata <= '0;
          end else if (a_sel == 3'b000) begin
            h_done  <= 1'b1;
            h_err   <= 1'b0;
            h_rdata <= '0;
          end else if (!h_we) begin
            st <= S_READ;
          end else if (h_addr[1:0] == 2'd0 && h_size == 3'd4) begin
            narrow_q <= 1'b0;
            st       <= S_WRITE;
          end else begin
            narrow_q <= 1'b1;
            st       <= S_FETCH;
          end
        end
        S_READ: begin
          h_rdata <= extracted;
          h_err   <= 1'b0;
          h_done  <= 1'b1;
          st      <= S_IDLE;
        end
        S_FETCH: begin
          merge_q <= merged;
          st      <= S_WRITE;
        end
        S_WRITE: begin
          h_rdata <= '0;
          h_err   <= 1'b0;
          h_done  <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(t_sel)); // R1
  AST_STROBE_TARGETED: assert property (@(posedge clk) disable iff (!rst_n)
    (t_rd || t_wr) |-> (t_sel != 3'b000) && !(t_rd && t_wr)); // R4
  AST_BUSY_WHILE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (t_rd || t_wr) |-> !h_ready); // R8
  AST_FETCH_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |=> t_wr && $stable(t_sel) && $stable(t_idx)); // R6
  AST_MERGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (t_wr && narrow_q) |-> (((t_wdata ^ $past(fetch_src)) & ~$past(lane_sh)) == 32'd0)); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_done && h_err) |-> (h_rdata == 32'd0)); // R10
endmodule

// File: tb/regwin_adapter_test.sv
`timescale 1ns/1ps
module regwin_adapter_test;
  localparam logic [31:0] CORE_XOR = 32'h0F0F_F0F0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_valid = 1'b0, h_we = 1'b0;
  logic [6:0] h_addr = '0;
  logic [2:0] h_size = '0;
  logic [31:0] h_wdata = '0;
  logic h_ready, h_done, h_err, t_rd, t_wr;
  logic [31:0] h_rdata, t_wdata;
  logic [2:0] t_sel;
  logic [3:0] t_idx;
  logic [31:0] core_rdata, core_wcopy, dma_rdata, ctl_rdata;

  always #10 clk = ~clk;

  regwin_adapter uut (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready), .h_we(h_we),
    .h_addr(h_addr), .h_size(h_size), .h_wdata(h_wdata), .h_done(h_done),
    .h_err(h_err), .h_rdata(h_rdata), .t_rd(t_rd), .t_wr(t_wr), .t_sel(t_sel),
    .t_idx(t_idx), .t_wdata(t_wdata), .core_rdata(core_rdata),
    .core_wcopy(core_wcopy), .dma_rdata(dma_rdata), .ctl_rdata(ctl_rdata));

  logic [31:0] core_m [16];
  logic [31:0] dma_m [8];
  logic [31:0] ctl_m;
  assign core_wcopy = core_m[t_idx];
  assign core_rdata = core_m[t_idx] ^ CORE_XOR;
  assign dma_rdata  = dma_m[t_idx[2:0]];
  assign ctl_rdata  = ctl_m;
  always @(posedge clk) if (t_wr) begin
    if (t_sel[0]) core_m[t_idx] <= t_wdata;
    if (t_sel[1]) dma_m[t_idx[2:0]] <= t_wdata;
    if (t_sel[2]) ctl_m <= t_wdata;
  end

  logic [31:0] ref_core [16];
  logic [31:0] ref_dma [8];
  logic [31:0] ref_ctl;

  typedef struct {
    logic [31:0] rdata;
    logic err;
    int lat, nrd, nwr;
    string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  bit inflight = 0, all_done = 0;
  int cyc = 0, nrd = 0, nwr = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (inflight) begin
    cyc++;
    if (t_rd) nrd++;
    if (t_wr) nwr++;
    if (cyc == 1 && sb.size() > 0 && sb[0].lat > 1)
      chk(h_ready == 1'b0, "R8", "h_ready while busy", 32'(h_ready), 32'd0);
    if (h_done) begin
      exp_t e;
      e = sb.pop_front();
      chk(h_rdata == e.rdata, e.tag, "rdata", h_rdata, e.rdata);
      chk(h_err == e.err, e.tag, "err", 32'(h_err), 32'(e.err));
      chk(cyc == e.lat, e.tag, "latency", 32'(cyc), 32'(e.lat));
      chk(nrd == e.nrd, e.tag, "read cycles", 32'(nrd), 32'(e.nrd));
      chk(nwr == e.nwr, e.tag, "write cycles", 32'(nwr), 32'(e.nwr));
      inflight = 0;
      cyc = 0; nrd = 0; nwr = 0;
    end
  end

  task automatic access(input bit we, input logic [6:0] addr, input int size,
                        input logic [31:0] wd, input string tag);
    exp_t e;
    int off, region, idx;
    logic [63:0] m64;
    logic [31:0] mask, cur;
    off = int'(addr[1:0]);
    region = 0; idx = 0;
    if (addr < 7'h40) begin region = 1; idx = int'(addr) / 4; end
    else if (addr < 7'h60) begin region = 2; idx = (int'(addr) - 64) / 4; end
    else if ({addr[6:2], 2'b00} == 7'h70) region = 3;
    m64 = (64'd1 << (8 * size)) - 64'd1;
    mask = m64[31:0];
    e.tag = tag; e.rdata = 0; e.err = 0; e.nrd = 0; e.nwr = 0; e.lat = 1;
    if (size < 1 || size > 4 || off + size > 4) e.err = 1;
    else if (region == 0) e.err = 0;
    else if (!we) begin
      cur = (region == 1) ? (ref_core[idx] ^ CORE_XOR) : (region == 2) ? ref_dma[idx] : ref_ctl;
      e.rdata = (cur >> (8 * off)) & mask;
      e.lat = 2; e.nrd = 1;
    end else begin
      cur = (region == 1) ? ref_core[idx] : (region == 2) ? ref_dma[idx] : ref_ctl;
      if (off == 0 && size == 4) begin
        cur = wd; e.lat = 2; e.nwr = 1;
      end else begin
        cur = (cur & ~(mask << (8 * off))) | ((wd & mask) << (8 * off));
        e.lat = 3; e.nrd = 1; e.nwr = 1;
      end
      if (region == 1) ref_core[idx] = cur;
      else if (region == 2) ref_dma[idx] = cur;
      else ref_ctl = cur;
    end
    sb.push_back(e);
    @(negedge clk);
    h_valid = 1'b1; h_we = we; h_addr = addr; h_size = 3'(size); h_wdata = wd;
    @(posedge clk);
    #1 h_valid = 1'b0;
    inflight = 1;
    wait (inflight == 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin core_m[i] = 32'(i) * 32'h0101_0101; ref_core[i] = core_m[i]; end
    for (int i = 0; i < 8; i++) begin dma_m[i] = 32'hD000_0000 + 32'(i); ref_dma[i] = dma_m[i]; end
    ctl_m = 32'hC0DE_0000; ref_ctl = ctl_m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(h_ready == 1'b1, "R11", "reset h_ready", 32'(h_ready), 32'd1);
    chk(h_done == 1'b0 && t_rd == 1'b0 && t_wr == 1'b0, "R11", "reset strobes",
        {29'd0, h_done, t_rd, t_wr}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    access(1, 7'h00, 4, 32'h1122_3344, "R5");
    access(1, 7'h3C, 4, 32'hCAFE_BABE, "R5");
    access(1, 7'h40, 4, 32'hA1B2_C3D4, "R1");
    access(1, 7'h5C, 4, 32'h5566_7788, "R1");
    access(1, 7'h70, 4, 32'h8765_4321, "R1");
    access(0, 7'h00, 4, 0, "R1");
    access(0, 7'h3C, 4, 0, "R2");
    access(0, 7'h41, 1, 0, "R2");
    access(0, 7'h43, 1, 0, "R2");
    access(0, 7'h5E, 2, 0, "R2");
    access(0, 7'h71, 3, 0, "R2");
    access(0, 7'h73, 1, 0, "R1");
    access(1, 7'h02, 1, 32'hFFFF_FF99, "R6");
    access(0, 7'h00, 4, 0, "R7");
    access(1, 7'h29, 2, 32'h0000_BEEF, "R7");
    access(0, 7'h28, 4, 0, "R7");
    access(1, 7'h46, 2, 32'h0000_1234, "R6");
    access(0, 7'h44, 4, 0, "R6");
    access(1, 7'h71, 3, 32'h00AB_CDEF, "R6");
    access(0, 7'h70, 4, 0, "R6");
    access(0, 7'h60, 4, 0, "R3");
    access(0, 7'h74, 1, 0, "R3");
    access(0, 7'h7F, 1, 0, "R3");
    access(1, 7'h64, 1, 32'h0000_00EE, "R4");
    access(1, 7'h78, 4, 32'hDEAD_DEAD, "R4");
    access(0, 7'h5C, 4, 0, "R4");
    access(0, 7'h70, 4, 0, "R4");
    access(0, 7'h04, 0, 0, "R9");
    access(1, 7'h04, 5, 32'h1111_1111, "R9");
    access(0, 7'h04, 4, 0, "R9");
    access(0, 7'h03, 2, 0, "R10");
    access(1, 7'h42, 4, 32'h2222_2222, "R10");
    access(0, 7'h40, 4, 0, "R10");
    access(1, 7'h4C, 4, 32'h0BAD_F00D, "R8");
    access(0, 7'h4D, 2, 0, "R8");

    all_done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!all_done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule